// File: doc/BRIEF.md
# Speculative Address Resolution Buffer

This block sits between a ring of speculative execution stages and data memory. It is a small associative buffer keyed on the memory address. Every entry keeps one load flag and one store flag for each stage, plus one buffered store value for each stage. Stores never reach memory while they are speculative. A load is served from the nearest store that is not younger than the load, and it falls back to memory when there is no such store. The block also catches the ordering hazard in which an older stage stores to an address that a younger stage has already read. In that case it names the oldest offending younger stage, so that the sequencer can throw that window and every window after it away.

Stages are numbered physically. Age is counted from the head stage that `head_i` names, so age = (stage − head) mod NUM_STAGES. When the sequencer commits the head window, the block drains that stage's buffered stores to memory one per cycle. It then acknowledges the commit and drops every flag that the stage held. An entry whose flags are all clear is free for reuse. A squash input removes the flags and data of any chosen set of stages.

Top module: `spec_addr_buf`

## Requirements
- R1: An address is held in at most one entry. An access to an address already held reuses that entry. An access to a new address takes the lowest-numbered free entry.
- R2: An accepted store never drives the memory write port. It sets its stage's store flag in the entry and records its data as that stage's value.
- R3: A load returns the buffered value of the store-flagged stage with the largest age that is not above the load's own age, the loading stage itself included, and it raises `ld_fwd_o`.
- R4: A load with no eligible store (untracked address, or only younger stores) raises `mem_re_o`, keeps `ld_fwd_o` low and returns `mem_rdata_i` for `mem_raddr_o` = `req_addr_i`.
- R5: An accepted store raises `viol_o` when any strictly younger stage has the load flag set in that entry, and `viol_stage_o` gives the youngest-but-oldest such stage (smallest age). Loads from the same or older stages never raise it.
- R6: While `commit_i` is high, no request is accepted. Each cycle, the lowest entry holding a head-stage store writes its address and the head's value on the memory write port and drops that flag. When none remain, `commit_ack_o` is high with no write.
- R7: In the acknowledge cycle, every head-stage load flag is cleared. Entries left with no flags are free again, and committed data is then visible to loads through memory.
- R8: A request to an untracked address while every entry is in use holds `req_ready_o` low and changes nothing. A request to a tracked address is still accepted.
- R9: `squash_i` clears the load flags, store flags and values of every stage whose bit is set in `squash_mask_i` (bit i = stage i). Flags of other stages survive. No request is accepted in that cycle.
- R10: After reset, all entries are free and `req_ready_o` is high. Ordering uses age relative to `head_i` with wrap-around, so a physically lower stage can be the youngest.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| head_i | input | log2(NUM_STAGES) | Physical index of the oldest stage |
| req_valid_i | input | 1 | Access request |
| req_store_i | input | 1 | 1 = store, 0 = load |
| req_stage_i | input | log2(NUM_STAGES) | Physical stage issuing the access |
| req_addr_i | input | ADDR_W | Access address |
| req_wdata_i | input | DATA_W | Store data |
| req_ready_o | output | 1 | Request accepted this cycle when valid |
| ld_data_o | output | DATA_W | Load result |
| ld_fwd_o | output | 1 | Load result came from a buffered store |
| viol_o | output | 1 | Ordering violation detected by the accepted store |
| viol_stage_o | output | log2(NUM_STAGES) | Oldest younger stage to squash |
| squash_i | input | 1 | Squash the stages in the mask |
| squash_mask_i | input | NUM_STAGES | Stages to squash, bit i = stage i |
| commit_i | input | 1 | Commit the head stage, held until acknowledged |
| commit_ack_o | output | 1 | Head stage fully drained and cleared |
| mem_re_o | output | 1 | Load reads memory |
| mem_raddr_o | output | ADDR_W | Memory read address |
| mem_rdata_i | input | DATA_W | Memory read data, same cycle |
| mem_we_o | output | 1 | Memory write of a committed store |
| mem_waddr_o | output | ADDR_W | Memory write address |
| mem_wdata_o | output | DATA_W | Memory write data |

## Verification
The assertions assume that `commit_i` stays high with `head_i` unchanged until `commit_ack_o`, and that commit and squash are never raised together. They also assume that `head_i` changes only between commits. The stimulus keeps to these rules: every request is driven as a single-cycle pulse, commits run to their acknowledge, and the head moves only after the acknowledge. A request overlaps a commit or a squash only to observe the refusal.

// File: rtl/sab_pkg.sv
package sab_pkg;

  // distance of a stage from the head, with wrap-around
  function automatic int unsigned stage_age(input int unsigned stg,
                                            input int unsigned head,
                                            input int unsigned n);
    return (stg >= head) ? (stg - head) : (stg + n - head);
  endfunction

endpackage

// File: rtl/sab_prio_enc.sv
module sab_prio_enc #(
  parameter int W  = 4,
  localparam int IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  req_i,
  output logic          hit_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    hit_o = |req_i;
    idx_o = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IW'(i);
    end
  end
endmodule

// File: rtl/sab_age_sel.sv
module sab_age_sel
  import sab_pkg::*;
#(
  parameter int NS = 4,
  localparam int SW = (NS > 1) ? $clog2(NS) : 1
) (
  input  logic [SW-1:0] head_i,
  input  logic [SW-1:0] ref_i,
  input  logic [NS-1:0] st_mask_i,
  input  logic [NS-1:0] ld_mask_i,
  output logic          near_hit_o,
  output logic [SW-1:0] near_stg_o,
  output logic          yng_hit_o,
  output logic [SW-1:0] yng_stg_o
);
  int unsigned ref_age;
  int unsigned near_best;
  int unsigned yng_best;

  always_comb begin
    ref_age    = stage_age(int'(ref_i), int'(head_i), NS);
    near_hit_o = 1'b0;
    near_stg_o = '0;
    yng_hit_o  = 1'b0;
    yng_stg_o  = '0;
    near_best  = 0;
    yng_best   = NS;
    for (int s = 0; s < NS; s++) begin
      // closest store at or before the reference stage
      if (st_mask_i[s] && stage_age(s, int'(head_i), NS) <= ref_age &&
          (!near_hit_o || stage_age(s, int'(head_i), NS) > near_best)) begin
        near_hit_o = 1'b1;
        near_best  = stage_age(s, int'(head_i), NS);
        near_stg_o = SW'(s);
      end
      // oldest load strictly after the reference stage
      if (ld_mask_i[s] && stage_age(s, int'(head_i), NS) > ref_age &&
          stage_age(s, int'(head_i), NS) < yng_best) begin
        yng_hit_o = 1'b1;
        yng_best  = stage_age(s, int'(head_i), NS);
        yng_stg_o = SW'(s);
      end
    end
  end
endmodule

// File: rtl/sab_entry.sv
module sab_entry #(
  parameter int NS = 4,
  parameter int AW = 16,
  parameter int DW = 32
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [AW-1:0]         lkup_addr_i,
  input  logic                  alloc_i,
  input  logic [NS-1:0]         ld_set_i,
  input  logic [NS-1:0]         st_set_i,
  input  logic [DW-1:0]         wdata_i,
  input  logic [NS-1:0]         ld_clr_i,
  input  logic [NS-1:0]         st_clr_i,
  output logic                  valid_o,
  output logic                  match_o,
  output logic [AW-1:0]         addr_o,
  output logic [NS-1:0]         ld_o,
  output logic [NS-1:0]         st_o,
  output logic [NS-1:0][DW-1:0] data_o
);
  logic [AW-1:0]         addr_q;
  logic [NS-1:0]         ld_q, st_q;
  logic [NS-1:0][DW-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      ld_q   <= '0;
      st_q   <= '0;
      data_q <= '0;
    end else begin
      if (alloc_i) addr_q <= lkup_addr_i;
      ld_q <= (ld_q & ~ld_clr_i) | ld_set_i;
      st_q <= (st_q & ~st_clr_i) | st_set_i;
      for (int s = 0; s < NS; s++) begin
        if (st_set_i[s])      data_q[s] <= wdata_i;
        else if (st_clr_i[s]) data_q[s] <= '0;
      end
    end
  end

  assign valid_o = |{ld_q, st_q};
  assign match_o = valid_o && (addr_q == lkup_addr_i);
  assign addr_o  = addr_q;
  assign ld_o    = ld_q;
  assign st_o    = st_q;
  assign data_o  = data_q;

  assert_alloc_free_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_i |-> !valid_o);

  assert_clear_ld_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_clr_i != '0) |=> ((ld_q & $past(ld_clr_i)) == '0));

  assert_clear_st_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_clr_i != '0) |=> ((st_q & $past(st_clr_i)) == '0));

  for (genvar s = 0; s < NS; s++) begin : g_chk
    assert_store_capture_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      st_set_i[s] |=> (st_q[s] && data_q[s] == $past(wdata_i)));
  end
endmodule

// File: rtl/spec_addr_buf.sv
module spec_addr_buf
  import sab_pkg::*;
#(
  parameter int NUM_STAGES  = 4,
  parameter int NUM_ENTRIES = 4,
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 32,
  localparam int SW = (NUM_STAGES > 1) ? $clog2(NUM_STAGES) : 1,
  localparam int EW = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [SW-1:0]         head_i,
  input  logic                  req_valid_i,
  input  logic                  req_store_i,
  input  logic [SW-1:0]         req_stage_i,
  input  logic [ADDR_W-1:0]     req_addr_i,
  input  logic [DATA_W-1:0]     req_wdata_i,
  output logic                  req_ready_o,
  output logic [DATA_W-1:0]     ld_data_o,
  output logic                  ld_fwd_o,
  output logic                  viol_o,
  output logic [SW-1:0]         viol_stage_o,
  input  logic                  squash_i,
  input  logic [NUM_STAGES-1:0] squash_mask_i,
  input  logic                  commit_i,
  output logic                  commit_ack_o,
  output logic                  mem_re_o,
  output logic [ADDR_W-1:0]     mem_raddr_o,
  input  logic [DATA_W-1:0]     mem_rdata_i,
  output logic                  mem_we_o,
  output logic [ADDR_W-1:0]     mem_waddr_o,
  output logic [DATA_W-1:0]     mem_wdata_o
);
  localparam int NS = NUM_STAGES;
  localparam int NE = NUM_ENTRIES;

  logic [NE-1:0]                 ent_valid, ent_match, ent_drain;
  logic [NE-1:0][ADDR_W-1:0]     ent_addr;
  logic [NE-1:0][NS-1:0]         ent_ld, ent_st;
  logic [NE-1:0][NS-1:0][DATA_W-1:0] ent_data;

  logic [NE-1:0][NS-1:0] ld_set, st_set, ld_clr, st_clr;
  logic [NE-1:0]         alloc;

  logic          hit, free_any, drain_any;
  logic [EW-1:0] hit_idx, free_idx, drain_idx;
  logic [NS-1:0] sel_ld, sel_st, stg_oh, head_oh;
  logic          near_hit, yng_hit;
  logic [SW-1:0] near_stg, yng_stg;
  logic          fire;

  // lookup, free slot and commit drain selection
  sab_prio_enc #(.W(NE)) u_hit   (.req_i(ent_match),  .hit_o(hit),       .idx_o(hit_idx));
  sab_prio_enc #(.W(NE)) u_free  (.req_i(~ent_valid), .hit_o(free_any),  .idx_o(free_idx));
  sab_prio_enc #(.W(NE)) u_drain (.req_i(ent_drain),  .hit_o(drain_any), .idx_o(drain_idx));

  always_comb begin
    for (int e = 0; e < NE; e++) ent_drain[e] = ent_st[e][head_i];
  end

  assign sel_ld = hit ? ent_ld[hit_idx] : '0;
  assign sel_st = hit ? ent_st[hit_idx] : '0;

  sab_age_sel #(.NS(NS)) u_age (
    .head_i    (head_i),
    .ref_i     (req_stage_i),
    .st_mask_i (sel_st),
    .ld_mask_i (sel_ld),
    .near_hit_o(near_hit),
    .near_stg_o(near_stg),
    .yng_hit_o (yng_hit),
    .yng_stg_o (yng_stg)
  );

  assign req_ready_o = !commit_i && !squash_i && (hit || free_any);
  assign fire        = req_valid_i && req_ready_o;

  assign ld_fwd_o     = fire && !req_store_i && hit && near_hit;
  assign ld_data_o    = ld_fwd_o ? ent_data[hit_idx][near_stg] : mem_rdata_i;
  assign mem_re_o     = fire && !req_store_i && !ld_fwd_o;
  assign mem_raddr_o  = req_addr_i;
  assign viol_o       = fire && req_store_i && hit && yng_hit;
  assign viol_stage_o = yng_stg;

  assign mem_we_o     = commit_i && drain_any;
  assign mem_waddr_o  = ent_addr[drain_idx];
  assign mem_wdata_o  = ent_data[drain_idx][head_i];
  assign commit_ack_o = commit_i && !drain_any;

  assign stg_oh  = NS'(1) << req_stage_i;
  assign head_oh = NS'(1) << head_i;

  always_comb begin
    for (int e = 0; e < NE; e++) begin
      logic tgt;
      tgt      = fire && (hit ? (hit_idx == EW'(e)) : (free_idx == EW'(e)));
      alloc[e] = fire && !hit && (free_idx == EW'(e));
      ld_set[e] = (tgt && !req_store_i) ? stg_oh : '0;
      st_set[e] = (tgt &&  req_store_i) ? stg_oh : '0;
      ld_clr[e] = (squash_i ? squash_mask_i : '0) | (commit_ack_o ? head_oh : '0);
      st_clr[e] = (squash_i ? squash_mask_i : '0) |
                  ((mem_we_o && drain_idx == EW'(e)) ? head_oh : '0);
    end
  end

  for (genvar e = 0; e < NE; e++) begin : g_ent
    sab_entry #(.NS(NS), .AW(ADDR_W), .DW(DATA_W)) u_ent (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .lkup_addr_i(req_addr_i),
      .alloc_i    (alloc[e]),
      .ld_set_i   (ld_set[e]),
      .st_set_i   (st_set[e]),
      .wdata_i    (req_wdata_i),
      .ld_clr_i   (ld_clr[e]),
      .st_clr_i   (st_clr[e]),
      .valid_o    (ent_valid[e]),
      .match_o    (ent_match[e]),
      .addr_o     (ent_addr[e]),
      .ld_o       (ent_ld[e]),
      .st_o       (ent_st[e]),
      .data_o     (ent_data[e])
    );
  end

  // stages still holding any flag, for the commit check
  logic [NS-1:0] stage_busy;
  always_comb begin
    stage_busy = '0;
    for (int e = 0; e < NE; e++) stage_busy |= ent_ld[e] | ent_st[e];
  end

  assert_match_unique_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(ent_match));

  assert_viol_younger_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    viol_o |-> (stage_age(int'(viol_stage_o), int'(head_i), NS) >
                stage_age(int'(req_stage_i), int'(head_i), NS)));

  assert_drain_distinct_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && $past(mem_we_o)) |-> (mem_waddr_o != $past(mem_waddr_o)));

  assert_commit_clears_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_ack_o |=> !stage_busy[$past(head_i)]);

  assert_stall_full_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !commit_i && !squash_i && !req_ready_o) |-> (&ent_valid && !(|ent_match)));
endmodule

// File: tb/sim_spec_addr_buf.sv
module sim_spec_addr_buf;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  head = '0;
  logic        req_valid = 1'b0, req_store = 1'b0;
  logic [1:0]  req_stage = '0;
  logic [15:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        req_ready, ld_fwd, viol, commit_ack, mem_re, mem_we;
  logic [31:0] ld_data, mem_rdata, mem_wdata;
  logic [1:0]  viol_stage;
  logic        squash = 1'b0, commit = 1'b0;
  logic [3:0]  squash_mask = '0;
  logic [15:0] mem_raddr, mem_waddr;

  logic [31:0] mem [0:255];
  int n_chk = 0, n_bad = 0;

  logic        s_ready, s_fwd, s_viol, s_re, s_we;
  logic [31:0] s_data;
  logic [1:0]  s_vstg;

  localparam logic [15:0] A = 16'h0010, B = 16'h0020, C = 16'h0030, D = 16'h0040, E = 16'h0050;
  localparam logic [31:0] D0 = 32'h0000_D000, D1 = 32'h1111_0001, D3 = 32'h3333_0003;
  localparam logic [31:0] D4 = 32'h4444_0040, DX = 32'h0BAD_0000, D5 = 32'h5555_0005;

  always #10 clk = ~clk;

  spec_addr_buf u0 (
    .clk_i(clk), .rst_ni(rst_n), .head_i(head),
    .req_valid_i(req_valid), .req_store_i(req_store), .req_stage_i(req_stage),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata), .req_ready_o(req_ready),
    .ld_data_o(ld_data), .ld_fwd_o(ld_fwd), .viol_o(viol), .viol_stage_o(viol_stage),
    .squash_i(squash), .squash_mask_i(squash_mask), .commit_i(commit),
    .commit_ack_o(commit_ack), .mem_re_o(mem_re), .mem_raddr_o(mem_raddr),
    .mem_rdata_i(mem_rdata), .mem_we_o(mem_we), .mem_waddr_o(mem_waddr),
    .mem_wdata_o(mem_wdata)
  );

  assign mem_rdata = mem[mem_raddr[7:0]];
  always @(posedge clk) if (mem_we) mem[mem_waddr[7:0]] <= mem_wdata;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic access(input logic st, input logic [1:0] stg, input logic [15:0] a,
                        input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_store = st; req_stage = stg; req_addr = a; req_wdata = d;
    #1;
    s_ready = req_ready; s_data = ld_data; s_fwd = ld_fwd; s_viol = viol;
    s_vstg = viol_stage; s_re = mem_re; s_we = mem_we;
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic t_reset;
    @(negedge clk); #1;
    chk("R10 ready after reset", 32'(req_ready), 32'd1);
    chk("R10 no write after reset", 32'(mem_we), 32'd0);
    chk("R10 no ack after reset", 32'(commit_ack), 32'd0);
  endtask

  task automatic t_forward;
    access(1'b1, 2'd1, A, D1);
    chk("R2 store accepted", 32'(s_ready), 32'd1);
    chk("R2 store no mem write", 32'(s_we), 32'd0);
    chk("R5 no viol first store", 32'(s_viol), 32'd0);
    access(1'b0, 2'd3, A, '0);
    chk("R3 fwd flag stage3", 32'(s_fwd), 32'd1);
    chk("R3 fwd data stage3", s_data, D1);
    access(1'b0, 2'd2, A, '0);
    chk("R3 fwd data stage2", s_data, D1);
    access(1'b1, 2'd0, A, D0);
    chk("R5 viol raised", 32'(s_viol), 32'd1);
    chk("R5 oldest younger stage", 32'(s_vstg), 32'd2);
    access(1'b0, 2'd0, A, '0);
    chk("R3 own store data", s_data, D0);
    access(1'b0, 2'd2, A, '0);
    chk("R3 closest older data", s_data, D1);
  endtask

  task automatic t_memory;
    access(1'b0, 2'd1, B, '0);
    chk("R4 miss reads memory", 32'(s_re), 32'd1);
    chk("R4 miss no fwd", 32'(s_fwd), 32'd0);
    chk("R4 miss data", s_data, 32'hA000_0020);
    access(1'b1, 2'd3, B, D3);
    chk("R5 older loads no viol", 32'(s_viol), 32'd0);
    access(1'b0, 2'd2, B, '0);
    chk("R4 younger store ignored fwd", 32'(s_fwd), 32'd0);
    chk("R4 younger store ignored data", s_data, 32'hA000_0020);
  endtask

  task automatic t_full;
    access(1'b0, 2'd0, C, '0);
    chk("R1 third entry", 32'(s_ready), 32'd1);
    access(1'b1, 2'd0, D, D4);
    chk("R1 fourth entry", 32'(s_ready), 32'd1);
    access(1'b0, 2'd1, E, '0);
    chk("R8 stall when full", 32'(s_ready), 32'd0);
    chk("R8 stalled no mem read", 32'(s_re), 32'd0);
    access(1'b0, 2'd1, A, '0);
    chk("R8 R1 tracked addr accepted", 32'(s_ready), 32'd1);
    chk("R3 stage1 own value", s_data, D1);
  endtask

  task automatic t_commit;
    logic [15:0] exp_a [0:1];
    logic [31:0] exp_d [0:1];
    exp_a[0] = A; exp_d[0] = D0; exp_a[1] = D; exp_d[1] = D4;
    @(negedge clk);
    commit = 1'b1;
    req_valid = 1'b1; req_store = 1'b0; req_stage = 2'd1; req_addr = E;
    for (int c = 0; c < 2; c++) begin
      #1;
      if (c == 0) chk("R6 no accept in commit", 32'(req_ready), 32'd0);
      chk("R6 drain write", 32'(mem_we), 32'd1);
      chk("R6 drain addr", 32'(mem_waddr), 32'(exp_a[c]));
      chk("R6 drain data", mem_wdata, exp_d[c]);
      chk("R6 no ack while draining", 32'(commit_ack), 32'd0);
      @(posedge clk); #1;
      req_valid = 1'b0;
      @(negedge clk);
    end
    #1;
    chk("R6 ack after drain", 32'(commit_ack), 32'd1);
    chk("R6 no write on ack", 32'(mem_we), 32'd0);
    @(posedge clk); #1;
    commit = 1'b0;
    head = 2'd1;
    chk("R6 memory A updated", mem[A[7:0]], D0);
    chk("R6 memory D updated", mem[D[7:0]], D4);
    access(1'b0, 2'd1, E, '0);
    chk("R7 freed entry reused", 32'(s_ready), 32'd1);
    chk("R7 new addr from memory", s_data, 32'hA000_0050);
    access(1'b0, 2'd2, D, '0);
    chk("R7 committed value via memory", s_data, D4);
    chk("R7 committed no fwd", 32'(s_fwd), 32'd0);
  endtask

  task automatic t_age;
    access(1'b1, 2'd0, A, DX);
    chk("R10 wrapped youngest no viol", 32'(s_viol), 32'd0);
    access(1'b0, 2'd2, A, '0);
    chk("R10 wrapped younger store skipped", s_data, D1);
    access(1'b1, 2'd1, B, D5);
    chk("R10 head store viol", 32'(s_viol), 32'd1);
    chk("R10 head store viol stage", 32'(s_vstg), 32'd2);
  endtask

  task automatic t_squash;
    @(negedge clk);
    squash = 1'b1; squash_mask = 4'b0010;
    req_valid = 1'b1; req_store = 1'b0; req_stage = 2'd2; req_addr = A;
    #1;
    chk("R9 no accept in squash", 32'(req_ready), 32'd0);
    @(posedge clk); #1;
    squash = 1'b0; squash_mask = '0; req_valid = 1'b0;
    access(1'b0, 2'd3, A, '0);
    chk("R9 squashed store gone fwd", 32'(s_fwd), 32'd0);
    chk("R9 squashed store gone data", s_data, D0);
    access(1'b0, 2'd0, A, '0);
    chk("R9 unsquashed store kept", s_data, DX);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'hA000_0000 + 32'(i);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_forward();
    t_memory();
    t_full();
    t_commit();
    t_age();
    t_squash();
    repeat (2) @(negedge clk);
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule